// File: doc/BRIEF.md
# Serial-Bus Monitor Channel Controller

This block moves single bytes across the monitor slot of a frame-based serial bus. Each frame carries a data byte plus two active-low handshake bits: MX, which flags a valid byte from the sender, and MR, which the receiver drives low to acknowledge it. The controller handles both directions at once. The host loads a byte to send, and the controller holds it on the bus until the far end acknowledges it or stops responding. In the other direction, the controller validates incoming bytes, captures them, acknowledges them and detects the end of a message.

The host works through four byte-wide registers, selected by a 2-bit address. Address 0 is the transmit data register and address 1 is the receive data register, which is read-only. Address 2 is the event status register, which is cleared when read. Address 3 is the control register. The bus framer pulses `frame_stb` for one clock once per frame. At that edge the controller samples the far end's slot values and updates its own slot outputs for the next frame.

The control register has four bits:
- bit 0: transmit enable
- bit 1: transmit interrupt enable
- bit 2: MR handshake enable
- bit 3: receive interrupt enable

The status register has four bits:
- bit 0: byte acknowledged
- bit 1: transfer aborted
- bit 2: end of message
- bit 3: byte received

Top module: `mon_chan_ctrl`

## Requirements
- R1: After reset the registers read as follows: transmit data 0xFF, receive data 0xFF, status 0x00 and control 0x00. The outputs are `tx_mon`=0xFF, `tx_mx`=1, `tx_mr`=1 and `irq`=0.
- R2: A status read (address 2) returns the pending bits and clears them. An event that occurs in the same cycle as the read is not in the returned value and stays pending for the next read.
- R3: `irq` is 1 exactly when some pending status bit has its direction's enable set. Bits 0 and 1 use control bit 1, and bits 2 and 3 use control bit 3.
- R4: An event is recorded in status only if its direction's interrupt enable (control bit 1 or bit 3) is 1 when the event occurs.
- R5: A write to address 0 while control bit 0 is 1 makes the next strobe drive that byte on `tx_mon` with `tx_mx`=0. The byte and MX are held unchanged until the transfer ends by acknowledge or abort. Between strobes, `tx_mon` and `tx_mx` never change.
- R6: With control bit 0 at 0, `tx_mx` is 1 after every strobe. Writes to address 0 made in that state never start a transfer. Clearing bit 0 during a transfer drops it without any event.
- R7: While a byte is out, MR is ignored in the first two frames the byte is on the bus. From the third frame on, MR=0 raises the acknowledge event (status bit 0) and returns `tx_mx` to 1 at that strobe.
- R8: If MR is 1 in both the third and the fourth frame of a byte, the abort event (status bit 1) is raised and the transmitter returns to idle with `tx_mx`=1.
- R9: A received byte is accepted when the same value arrives with MX=0 in two consecutive frames. Each such run is accepted only once. The accepted byte appears at address 1.
- R10: With control bit 2 at 1, each accepted byte drives `tx_mr`=0 for exactly the one following frame, and each accepted byte raises the byte-received event (status bit 3).
- R11: With control bit 2 at 0, `tx_mr` is always 1, and only the first byte of a message raises the byte-received event. Later bytes still update address 1.
- R12: After at least one byte of a message has been accepted, MX=1 in two consecutive frames raises the end-of-message event (status bit 2) and ends the message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (clears status when address is 2) |
| host_addr | input | 2 | Register select |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Read data, combinational from address |
| frame_stb | input | 1 | One-clock pulse per bus frame |
| rx_mon | input | DATA_W | Monitor byte seen on the bus in the frame just ended |
| rx_mx | input | 1 | Far-end MX bit of that frame (active low) |
| rx_mr | input | 1 | Far-end MR bit of that frame (active low) |
| tx_mon | output | DATA_W | Monitor byte to drive in the next frame |
| tx_mx | output | 1 | MX bit to drive (active low) |
| tx_mr | output | 1 | MR bit to drive (active low) |
| irq | output | 1 | Interrupt request |

## Verification
Some rules hold on every clock, and the assertions check those:
- the slot outputs stay frozen between strobes;
- MX is released whenever transmission is disabled;
- MR stays high when the handshake is off and never stays low for two strobes running;
- a status read outside a strobe leaves status empty;
- an acknowledge bit only rises while its enable is set.

Other behaviours depend on a sequence of frames and only the bench scenarios can show them:
- the two-frame grace window before acknowledges count;
- the exact strobe where an abort fires;
- accept-once on repeated bytes and rejection of a changing value;
- first-byte-only receive events in the forced-MR mode;
- a status bit that is set in the same cycle as a read surviving that read.

// File: rtl/mon_pkg.sv
// Shared register selects and bit positions for the monitor channel controller.
package mon_pkg;
    typedef enum logic [1:0] {
        REG_TXD  = 2'd0,
        REG_RXD  = 2'd1,
        REG_STAT = 2'd2,
        REG_CTRL = 2'd3
    } reg_sel_e;

    localparam int CTRL_W  = 4;
    localparam int STAT_W  = 4;
    // control bits
    localparam int CT_TXEN = 0;
    localparam int CT_TXIE = 1;
    localparam int CT_MRC  = 2;
    localparam int CT_RXIE = 3;
    // status bits
    localparam int ST_ACK  = 0;
    localparam int ST_ABT  = 1;
    localparam int ST_EOM  = 2;
    localparam int ST_DRX  = 3;
endpackage

// File: rtl/mon_host_regs.sv
// Host register file: transmit/control registers, read-to-clear status and irq.
// Assumes DATA_W >= CTRL_W. Events arrive as single-cycle pulses; status
// records only events whose direction enable is set in the current control value.
module mon_host_regs
    import mon_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] rxd,
    input  logic              load,
    input  logic              ev_ack,
    input  logic              ev_abort,
    input  logic              ev_eom,
    input  logic              ev_drx,
    output logic [DATA_W-1:0] txd,
    output logic              pend,
    output logic [CTRL_W-1:0] ctrl,
    output logic [STAT_W-1:0] status,
    output logic              irq
);
    logic              wr_txd, wr_ctrl, rd_stat;
    logic [STAT_W-1:0] ev_vec, en_vec;

    // Decode host strobes and build masked event vector.
    always_comb begin
        wr_txd  = wr_en && (addr == REG_TXD);
        wr_ctrl = wr_en && (addr == REG_CTRL);
        rd_stat = rd_en && (addr == REG_STAT);
        en_vec  = '0;
        en_vec[ST_ACK] = ctrl[CT_TXIE];
        en_vec[ST_ABT] = ctrl[CT_TXIE];
        en_vec[ST_EOM] = ctrl[CT_RXIE];
        en_vec[ST_DRX] = ctrl[CT_RXIE];
        ev_vec  = '0;
        ev_vec[ST_ACK] = ev_ack;
        ev_vec[ST_ABT] = ev_abort;
        ev_vec[ST_EOM] = ev_eom;
        ev_vec[ST_DRX] = ev_drx;
        ev_vec  = ev_vec & en_vec;
        irq     = |(status & en_vec);
    end

    // Register writes, pending-transmit flag and read-to-clear status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txd    <= '1;
            ctrl   <= '0;
            status <= '0;
            pend   <= 1'b0;
        end else begin
            if (wr_txd)  txd  <= wdata;
            if (wr_ctrl) ctrl <= wdata[CTRL_W-1:0];
            if (wr_txd && ctrl[CT_TXEN])       pend <= 1'b1;
            else if (load || !ctrl[CT_TXEN])   pend <= 1'b0;
            status <= (rd_stat ? '0 : status) | ev_vec;
        end
    end

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        case (addr)
            REG_TXD:  rdata = txd;
            REG_RXD:  rdata = rxd;
            REG_STAT: rdata[STAT_W-1:0] = status;
            default:  rdata[CTRL_W-1:0] = ctrl;
        endcase
    end
endmodule

// File: rtl/mon_tx_fsm.sv
// Transmit side: puts a pending byte on the bus with MX low and waits for MR low.
// MR is ignored for GRACE_FRAMES frames (far end's validation window); after
// ABORT_FRAMES further frames with MR high the transfer is aborted.
module mon_tx_fsm #(
    parameter int DATA_W       = 8,
    parameter int GRACE_FRAMES = 2,
    parameter int ABORT_FRAMES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_stb,
    input  logic              tx_en,
    input  logic              pend,
    input  logic [DATA_W-1:0] txd,
    input  logic              rx_mr,
    output logic              load,
    output logic              ev_ack,
    output logic              ev_abort,
    output logic [DATA_W-1:0] tx_mon,
    output logic              tx_mx
);
    localparam int LIMIT = GRACE_FRAMES + ABORT_FRAMES;
    localparam int CNT_W = $clog2(LIMIT + 1);

    typedef enum logic {TX_IDLE, TX_BUSY} tx_st_e;

    tx_st_e           st;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic             in_win, busy_stb;

    // Frame-level decisions for the current strobe.
    always_comb begin
        cnt_nx   = cnt + CNT_W'(1);
        in_win   = cnt_nx > CNT_W'(GRACE_FRAMES);
        busy_stb = frame_stb && tx_en && (st == TX_BUSY);
        load     = frame_stb && tx_en && (st == TX_IDLE) && pend;
        ev_ack   = busy_stb && in_win && !rx_mr;
        ev_abort = busy_stb && in_win && rx_mr && (cnt_nx == CNT_W'(LIMIT));
    end

    // Slot outputs and state advance once per frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= TX_IDLE;
            cnt    <= '0;
            tx_mon <= '1;
            tx_mx  <= 1'b1;
        end else if (frame_stb) begin
            if (!tx_en) begin
                st     <= TX_IDLE;
                tx_mon <= '1;
                tx_mx  <= 1'b1;
            end else if (load) begin
                st     <= TX_BUSY;
                cnt    <= '0;
                tx_mon <= txd;
                tx_mx  <= 1'b0;
            end else if (st == TX_BUSY) begin
                if (ev_ack || ev_abort) begin
                    st     <= TX_IDLE;
                    tx_mon <= '1;
                    tx_mx  <= 1'b1;
                end else begin
                    cnt <= cnt_nx;
                end
            end
        end
    end
endmodule

// File: rtl/mon_rx_fsm.sv
// Receive side: two-frame value match with MX low accepts a byte once, drives
// a one-frame MR acknowledge when the handshake is enabled, and detects the
// end of a message after EOM_FRAMES frames of MX high.
module mon_rx_fsm #(
    parameter int DATA_W     = 8,
    parameter int EOM_FRAMES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_stb,
    input  logic [DATA_W-1:0] rx_mon,
    input  logic              rx_mx,
    input  logic              mr_ctl,
    output logic              ev_drx,
    output logic              ev_eom,
    output logic [DATA_W-1:0] rxd,
    output logic              tx_mr
);
    localparam int Q_W = $clog2(EOM_FRAMES + 1);

    logic [DATA_W-1:0] prev_mon;
    logic              prev_mx, taken, in_msg, mr_q, same_val, accept;
    logic [Q_W-1:0]    quiet, quiet_nx;

    // Acceptance and end-of-message detection for this strobe.
    always_comb begin
        same_val = (rx_mon == prev_mon);
        accept   = frame_stb && !rx_mx && !prev_mx && same_val && !taken;
        quiet_nx = quiet + Q_W'(1);
        ev_eom   = frame_stb && in_msg && rx_mx && (quiet_nx == Q_W'(EOM_FRAMES));
        ev_drx   = accept && (mr_ctl || !in_msg);
        tx_mr    = mr_q || !mr_ctl;
    end

    // Per-frame history, captured byte and acknowledge bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_mon <= '1;
            prev_mx  <= 1'b1;
            taken    <= 1'b0;
            in_msg   <= 1'b0;
            quiet    <= '0;
            mr_q     <= 1'b1;
            rxd      <= '1;
        end else if (frame_stb) begin
            prev_mon <= rx_mon;
            prev_mx  <= rx_mx;
            taken    <= !rx_mx && (accept || (taken && same_val));
            mr_q     <= !accept;
            if (accept) rxd <= rx_mon;
            if (accept)      in_msg <= 1'b1;
            else if (ev_eom) in_msg <= 1'b0;
            quiet <= (rx_mx && in_msg && !ev_eom) ? quiet_nx : '0;
        end
    end
endmodule

// File: rtl/mon_chan_ctrl.sv
// Monitor channel controller top: host registers plus transmit and receive
// handshake engines. Assumes frame_stb is a single-cycle pulse per frame and
// rx_* are valid in that cycle.
module mon_chan_ctrl
    import mon_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int GRACE_FRAMES = 2,
    parameter int ABORT_FRAMES = 2,
    parameter int EOM_FRAMES   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [1:0]        host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              frame_stb,
    input  logic [DATA_W-1:0] rx_mon,
    input  logic              rx_mx,
    input  logic              rx_mr,
    output logic [DATA_W-1:0] tx_mon,
    output logic              tx_mx,
    output logic              tx_mr,
    output logic              irq
);
    logic [DATA_W-1:0] txd_q, rxd_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic [STAT_W-1:0] status_q;
    logic              pend, load, ev_ack, ev_abort, ev_eom, ev_drx;

    mon_host_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(host_wr), .rd_en(host_rd), .addr(host_addr),
        .wdata(host_wdata), .rdata(host_rdata), .rxd(rxd_q),
        .load(load), .ev_ack(ev_ack), .ev_abort(ev_abort),
        .ev_eom(ev_eom), .ev_drx(ev_drx),
        .txd(txd_q), .pend(pend), .ctrl(ctrl_q), .status(status_q), .irq(irq)
    );

    mon_tx_fsm #(
        .DATA_W(DATA_W), .GRACE_FRAMES(GRACE_FRAMES), .ABORT_FRAMES(ABORT_FRAMES)
    ) u_tx (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb),
        .tx_en(ctrl_q[CT_TXEN]), .pend(pend), .txd(txd_q), .rx_mr(rx_mr),
        .load(load), .ev_ack(ev_ack), .ev_abort(ev_abort),
        .tx_mon(tx_mon), .tx_mx(tx_mx)
    );

    mon_rx_fsm #(.DATA_W(DATA_W), .EOM_FRAMES(EOM_FRAMES)) u_rx (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb),
        .rx_mon(rx_mon), .rx_mx(rx_mx), .mr_ctl(ctrl_q[CT_MRC]),
        .ev_drx(ev_drx), .ev_eom(ev_eom), .rxd(rxd_q), .tx_mr(tx_mr)
    );
endmodule

// File: rtl/mon_chan_chk.sv
// Property checker for mon_chan_ctrl, attached by bind below.
module mon_chan_chk
    import mon_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_stb,
    input logic              host_rd,
    input logic [1:0]        host_addr,
    input logic [DATA_W-1:0] tx_mon,
    input logic              tx_mx,
    input logic              tx_mr,
    input logic              irq,
    input logic [CTRL_W-1:0] ctrl,
    input logic [STAT_W-1:0] status
);
    // R2
    rd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == REG_STAT && !frame_stb) |=> (status == '0));
    // R3
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl[CT_TXIE] && !ctrl[CT_RXIE]) |-> !irq);
    // R4
    ack_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[ST_ACK]) |-> $past(ctrl[CT_TXIE]));
    // R5
    slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> ($stable(tx_mon) && $stable(tx_mx)));
    // R6
    mx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && !ctrl[CT_TXEN]) |=> tx_mx);
    // R10
    mr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && !tx_mr) |=> tx_mr);
    // R11
    mr_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[CT_MRC] |-> tx_mr);
endmodule

bind mon_chan_ctrl mon_chan_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb),
    .host_rd(host_rd), .host_addr(host_addr),
    .tx_mon(tx_mon), .tx_mx(tx_mx), .tx_mr(tx_mr), .irq(irq),
    .ctrl(ctrl_q), .status(status_q)
);

// File: tb/test_mon_chan_ctrl.sv
// Bench: behavioural reference model compared every clock, plus directed scenarios.
module test_mon_chan_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [1:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       frame_stb = 1'b0;
    logic [7:0] rx_mon = 8'hFF;
    logic       rx_mx = 1'b1, rx_mr = 1'b1;
    logic [7:0] tx_mon;
    logic       tx_mx, tx_mr, irq;

    int n_vec = 0, n_bad = 0;
    bit cmp_on = 1'b0;

    mon_chan_ctrl i_mon_chan_ctrl (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .frame_stb(frame_stb), .rx_mon(rx_mon), .rx_mx(rx_mx), .rx_mr(rx_mr),
        .tx_mon(tx_mon), .tx_mx(tx_mx), .tx_mr(tx_mr), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- reference model ----------------
    int m_txd, m_rxd, m_ctrl, m_stat, m_age, m_out, m_lastmon, m_quiet, ev;
    bit m_pend, m_mxo, m_mro, m_lastmx, m_got, m_msg, acc, fin;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_txd = 8'hFF; m_rxd = 8'hFF; m_ctrl = 0; m_stat = 0; m_age = 0;
            m_out = 8'hFF; m_lastmon = 8'hFF; m_quiet = 0; m_pend = 0;
            m_mxo = 1; m_mro = 1; m_lastmx = 1; m_got = 0; m_msg = 0;
        end else begin
            ev = 0;
            if (frame_stb) begin
                if (!m_ctrl[0]) begin m_age = 0; m_mxo = 1; m_out = 8'hFF; end
                else if (m_age == 0) begin
                    if (m_pend) begin m_out = m_txd; m_mxo = 0; m_age = 1; m_pend = 0; end
                end else if (m_age > 2 && !rx_mr) begin
                    ev |= 1; m_age = 0; m_mxo = 1; m_out = 8'hFF;
                end else if (m_age == 4) begin
                    ev |= 2; m_age = 0; m_mxo = 1; m_out = 8'hFF;
                end else m_age++;
                acc = !rx_mx && !m_lastmx && (rx_mon == m_lastmon) && !m_got;
                fin = m_msg && rx_mx && (m_quiet == 1);
                if (acc) begin
                    m_rxd = rx_mon;
                    if (m_ctrl[2] || !m_msg) ev |= 8;
                end
                if (fin) ev |= 4;
                m_got   = !rx_mx && (acc || (m_got && rx_mon == m_lastmon));
                m_quiet = (rx_mx && m_msg) ? m_quiet + 1 : 0;
                if (acc) m_msg = 1; else if (fin) m_msg = 0;
                m_mro = !acc; m_lastmon = rx_mon; m_lastmx = rx_mx;
            end
            if (!m_ctrl[0]) m_pend = 0;
            if (!m_ctrl[1]) ev &= ~3;
            if (!m_ctrl[3]) ev &= ~12;
            if (host_rd && host_addr == 2) m_stat = 0;
            m_stat |= ev;
            if (host_wr && host_addr == 0) begin
                m_txd = host_wdata;
                if (m_ctrl[0]) m_pend = 1;
            end
            if (host_wr && host_addr == 3) m_ctrl = host_wdata[3:0];
            cmp_on = 1'b1;
        end
    end

    function automatic int exp_irq();
        return ((m_stat & 3) != 0 && m_ctrl[1]) || ((m_stat & 12) != 0 && m_ctrl[3]);
    endfunction

    task automatic chk(string req, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Every-clock comparison against the model.
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            chk("R5 tx_mon", tx_mon, m_out);
            chk("R5 tx_mx", tx_mx, m_mxo);
            chk("R10 tx_mr", tx_mr, m_mro | !m_ctrl[2]);
            chk("R3 irq", irq, exp_irq());
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); host_wr = 1; host_addr = a; host_wdata = d;
        @(negedge clk); host_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        int e;
        @(negedge clk); host_rd = 1; host_addr = a;
        #1; v = host_rdata;
        case (a)
            2'd0: e = m_txd;
            2'd1: e = m_rxd;
            2'd2: e = m_stat;
            default: e = m_ctrl;
        endcase
        chk("R2 readback", v, e);
        @(negedge clk); host_rd = 0;
    endtask

    task automatic frm(input logic [7:0] d, input logic mx, input logic mr, input bit with_rd = 0);
        @(negedge clk);
        rx_mon = d; rx_mx = mx; rx_mr = mr; frame_stb = 1;
        if (with_rd) begin host_rd = 1; host_addr = 2'd2; end
        @(negedge clk); frame_stb = 0; host_rd = 0;
        repeat (2) @(negedge clk);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : scenario
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        rd(2'd0, v); chk("R1 txd", v, 8'hFF);
        rd(2'd1, v); chk("R1 rxd", v, 8'hFF);
        rd(2'd2, v); chk("R1 status", v, 0);
        rd(2'd3, v); chk("R1 ctrl", v, 0);
        chk("R1 tx_mx", tx_mx, 1); chk("R1 tx_mr", tx_mr, 1);
        chk("R1 tx_mon", tx_mon, 8'hFF); chk("R1 irq", irq, 0);

        // R5/R7: send and acknowledge
        wr(2'd3, 8'h03); wr(2'd0, 8'h5A);
        frm(8'hFF, 1, 1);
        chk("R5 byte out", tx_mon, 8'h5A); chk("R5 mx low", tx_mx, 0);
        frm(8'hFF, 1, 0); chk("R7 grace ignores MR", tx_mx, 0);
        frm(8'hFF, 1, 1); chk("R7 still waiting", tx_mx, 0);
        frm(8'hFF, 1, 0); chk("R7 ack releases mx", tx_mx, 1);
        chk("R3 irq on ack", irq, 1);
        rd(2'd2, v); chk("R7 ack bit", v, 8'h01);
        rd(2'd2, v); chk("R2 cleared", v, 0);
        chk("R3 irq after clear", irq, 0);

        // R8: abort
        wr(2'd0, 8'h33);
        frm(8'hFF, 1, 1);
        repeat (3) frm(8'hFF, 1, 1);
        chk("R8 before limit", tx_mx, 0);
        frm(8'hFF, 1, 1); chk("R8 idle after abort", tx_mx, 1);
        rd(2'd2, v); chk("R8 abort bit", v, 8'h02);

        // R4: transmit events masked
        wr(2'd3, 8'h01); wr(2'd0, 8'h44);
        repeat (5) frm(8'hFF, 1, 1);
        chk("R4 masked irq", irq, 0);
        rd(2'd2, v); chk("R4 masked abort", v, 0);

        // R6: transmit disabled
        wr(2'd3, 8'h02); wr(2'd0, 8'h77);
        frm(8'hFF, 1, 1); chk("R6 mx idle", tx_mx, 1);
        wr(2'd3, 8'h03);
        frm(8'hFF, 1, 1); chk("R6 stale write not sent", tx_mx, 1);
        wr(2'd0, 8'h88); frm(8'hFF, 1, 1); chk("R5 new byte", tx_mon, 8'h88);
        wr(2'd3, 8'h02); frm(8'hFF, 1, 1); chk("R6 drop on disable", tx_mx, 1);
        rd(2'd2, v); chk("R6 no event", v, 0);

        // R9/R10/R12: receive with handshake
        wr(2'd3, 8'h0C);
        frm(8'hA1, 0, 1); chk("R9 one frame not enough", tx_mr, 1);
        frm(8'hA1, 0, 1); chk("R10 ack low", tx_mr, 0);
        rd(2'd1, v); chk("R9 rxd", v, 8'hA1);
        rd(2'd2, v); chk("R10 drx", v, 8'h08);
        frm(8'hA1, 0, 1); chk("R10 ack one frame", tx_mr, 1);
        rd(2'd2, v); chk("R9 accepted once", v, 0);
        frm(8'hFF, 1, 1);
        frm(8'hA2, 0, 1); frm(8'hA2, 0, 1);
        rd(2'd2, v); chk("R10 drx every byte", v, 8'h08);
        frm(8'hFF, 1, 1);
        rd(2'd2, v); chk("R12 one idle frame", v, 0);
        frm(8'hFF, 1, 1);
        rd(2'd2, v); chk("R12 end of message", v, 8'h04);
        frm(8'hC1, 0, 1); frm(8'hC2, 0, 1);
        rd(2'd1, v); chk("R9 changing value rejected", v, 8'hA2);
        frm(8'hC2, 0, 1);
        rd(2'd1, v); chk("R9 stable value accepted", v, 8'hC2);
        frm(8'hFF, 1, 1); frm(8'hFF, 1, 1);
        rd(2'd2, v);

        // R11: forced MR mode
        wr(2'd3, 8'h08);
        frm(8'hB1, 0, 1); frm(8'hB1, 0, 1); chk("R11 mr high", tx_mr, 1);
        rd(2'd2, v); chk("R11 first byte drx", v, 8'h08);
        frm(8'hFF, 1, 1);
        frm(8'hB2, 0, 1); frm(8'hB2, 0, 1); chk("R11 mr high 2", tx_mr, 1);
        rd(2'd1, v); chk("R11 rxd updated", v, 8'hB2);
        rd(2'd2, v); chk("R11 no drx later byte", v, 0);
        frm(8'hFF, 1, 1); frm(8'hFF, 1, 1);
        rd(2'd2, v); chk("R12 eom forced mode", v, 8'h04);

        // R4: receive events masked
        wr(2'd3, 8'h04);
        frm(8'hD1, 0, 1); frm(8'hD1, 0, 1);
        rd(2'd2, v); chk("R4 rx masked", v, 0);
        rd(2'd1, v); chk("R4 rxd still captured", v, 8'hD1);
        frm(8'hFF, 1, 1); frm(8'hFF, 1, 1);

        // R2/R3: event in the same cycle as a read
        wr(2'd3, 8'h0C);
        frm(8'hE1, 0, 1);
        frm(8'hE1, 0, 1, 1);
        wr(2'd3, 8'h04); chk("R3 irq masked", irq, 0);
        wr(2'd3, 8'h0C); chk("R3 irq unmasked", irq, 1);
        rd(2'd2, v); chk("R2 survives same-cycle read", v, 8'h08);
        frm(8'hFF, 1, 1); frm(8'hFF, 1, 1);

        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule